// File: doc/BRIEF.md
# Breakpoint and Watchpoint Debug Unit

This block watches a processor's instruction-fetch bus and data-access bus with two programmable compare units. Each unit is set up either as a breakpoint, which compares fetch addresses, or as a watchpoint, which compares data-access addresses and can be limited to reads, writes or both. Either kind may also require a masked data value to match before it fires. An external debug request acts like a compare hit.

When something fires, the global debug mode decides the response. In halt mode the block raises `core_halt`, which stops and isolates the core until a run command arrives. In monitor mode the block instead raises a one-cycle `dbg_exc` pulse and the core keeps running. Run, halt and single-step commands arrive through a simple register write port. A sticky status field records which source fired.

Top module: `bpwp_dbg`

## Requirements
- R1: After reset, `core_halt`, `dbg_exc` and `hit_status` are 0 and both units are disabled. A unit whose control bit 0 (enable) is 0 never matches.
- R2: A unit whose control bit 1 is 0 is a breakpoint. It matches a valid fetch when `if_addr` equals its address value in every bit where its address mask is 0, and it ignores data accesses.
- R3: A unit whose control bit 1 is 1 is a watchpoint. It matches a valid data access under the same masked address rule, but only when the access direction is allowed: control bit 2 allows reads and control bit 3 allows writes. It ignores fetches.
- R4: When control bit 4 is set, a unit also requires its data value to match the bus data (`if_data` for a breakpoint, `da_data` for a watchpoint) in every bit where its data mask is 0.
- R5: Outputs are registered: they respond on the clock edge that samples the transaction. `hit_status` bit 0 records unit 0, bit 1 records unit 1 and bit 2 records an external request. The bits stay set until any write to offset 2. A hit sampled in the same cycle as that write is still recorded.
- R6: In halt mode (offset 0 bit 0 = 0), a hit or request sets `core_halt`. `core_halt` then stays high until a run or step command releases it.
- R7: In monitor mode (offset 0 bit 0 = 1), a hit or request produces a one-cycle `dbg_exc` pulse and leaves `core_halt` unchanged.
- R8: `ext_dbg_req` triggers the same response as a compare hit in both modes.
- R9: A write to offset 1 issues commands: bit 0 is run (clears the halt), bit 1 is halt (sets it), and bit 2 is step. Step releases a halted core until the next `insn_retire`, after which the core halts again. Step is ignored while the core is running.
- R10: Each unit's registers sit at offset 8 (unit 0) or 16 (unit 1), plus 0 for the address value, 1 for the address mask (a 1 bit means don't care), 2 for the data value, 3 for the data mask and 4 for control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register offset |
| cfg_wdata | input | W | Register write data |
| if_valid | input | 1 | Fetch transaction valid |
| if_addr | input | W | Fetch address |
| if_data | input | W | Fetched instruction word |
| insn_retire | input | 1 | One instruction retired this cycle |
| da_valid | input | 1 | Data access valid |
| da_write | input | 1 | Data access is a write |
| da_addr | input | W | Data access address |
| da_data | input | W | Data access value |
| ext_dbg_req | input | 1 | External debug request |
| core_halt | output | 1 | Stop and isolate the core |
| dbg_exc | output | 1 | Debug exception pulse (monitor mode) |
| hit_status | output | 3 | Sticky record of ext/unit1/unit0 hits |

## Verification
The compare logic is tried with a set of fetch and data transactions. These separate the following cases: a masked address that matches from one that differs just above the mask; a matching address that is rejected by the data qualifier; a write from a read on a write-only watchpoint; and a breakpoint address seen on the data bus from a watchpoint address seen on the fetch bus. Directed sequences then cover the halt and monitor responses to hits and external requests. They also cover single-step against step-while-running, and a status clear that coincides with a new hit. Finally, a unit is disabled after it has already matched, to confirm it no longer fires.

// File: rtl/bpwp_dbg.sv
module bpwp_dbg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [4:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         if_valid,
  input  logic [W-1:0] if_addr,
  input  logic [W-1:0] if_data,
  input  logic         insn_retire,
  input  logic         da_valid,
  input  logic         da_write,
  input  logic [W-1:0] da_addr,
  input  logic [W-1:0] da_data,
  input  logic         ext_dbg_req,
  output logic         core_halt,
  output logic         dbg_exc,
  output logic [2:0]   hit_status
);
  localparam int NU = 2;

  logic [W-1:0] a_val [NU];
  logic [W-1:0] a_msk [NU];
  logic [W-1:0] d_val [NU];
  logic [W-1:0] d_msk [NU];
  logic [4:0]   ctl   [NU];
  logic         mon_mode;
  logic         halted;
  logic         step_arm;
  logic         exc_q;
  logic [2:0]   status;
  logic [NU-1:0] hit;

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic         is_wp;
    logic         vld;
    logic         dir_ok;
    logic [W-1:0] ca;
    logic [W-1:0] cd;
    assign is_wp  = ctl[u][1];
    assign vld    = is_wp ? da_valid : if_valid;
    assign dir_ok = !is_wp || (da_write ? ctl[u][3] : ctl[u][2]);
    assign ca     = is_wp ? da_addr : if_addr;
    assign cd     = is_wp ? da_data : if_data;
    assign hit[u] = ctl[u][0] && vld && dir_ok &&
                    (((ca ^ a_val[u]) & ~a_msk[u]) == '0) &&
                    (!ctl[u][4] || (((cd ^ d_val[u]) & ~d_msk[u]) == '0));
  end

  logic cmd_wr, run_c, halt_c, step_c, clr_c, trig, halt_set;
  assign cmd_wr   = cfg_we && (cfg_addr == 5'd1);
  assign run_c    = cmd_wr && cfg_wdata[0];
  assign halt_c   = cmd_wr && cfg_wdata[1];
  assign step_c   = cmd_wr && cfg_wdata[2] && halted;
  assign clr_c    = cfg_we && (cfg_addr == 5'd2);
  assign trig     = (|hit) || ext_dbg_req;
  assign halt_set = (trig && !mon_mode) || halt_c || (step_arm && insn_retire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        a_val[u] <= '0;
        a_msk[u] <= '0;
        d_val[u] <= '0;
        d_msk[u] <= '0;
        ctl[u]   <= '0;
      end
      mon_mode <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == 5'd0) mon_mode <= cfg_wdata[0];
      for (int u = 0; u < NU; u++) begin
        if (cfg_addr[4:3] == 2'(u + 1)) begin
          case (cfg_addr[2:0])
            3'd0: a_val[u] <= cfg_wdata;
            3'd1: a_msk[u] <= cfg_wdata;
            3'd2: d_val[u] <= cfg_wdata;
            3'd3: d_msk[u] <= cfg_wdata;
            3'd4: ctl[u]   <= cfg_wdata[4:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted   <= 1'b0;
      step_arm <= 1'b0;
      exc_q    <= 1'b0;
      status   <= '0;
    end else begin
      if (halt_set)            halted <= 1'b1;
      else if (run_c || step_c) halted <= 1'b0;
      if (step_c && !halt_set) step_arm <= 1'b1;
      else if (insn_retire || halt_set || run_c) step_arm <= 1'b0;
      exc_q  <= trig && mon_mode;
      status <= (clr_c ? 3'b000 : status) | {ext_dbg_req, hit};
    end
  end

  assign core_halt  = halted;
  assign dbg_exc    = exc_q;
  assign hit_status = status;
endmodule

// File: rtl/bpwp_dbg_chk.sv
module bpwp_dbg_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic [4:0]   cfg_addr,
  input logic [W-1:0] cfg_wdata,
  input logic         if_valid,
  input logic         da_valid,
  input logic         ext_dbg_req,
  input logic         mon_mode,
  input logic         core_halt,
  input logic         dbg_exc,
  input logic [2:0]   hit_status
);
  logic release_cmd;
  assign release_cmd = cfg_we && (cfg_addr == 5'd1) && (cfg_wdata[0] || cfg_wdata[2]);

  AST_EXC_ONLY_MONITOR: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exc |-> $past(mon_mode)); // R7
  AST_EXT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_dbg_req && !mon_mode) |=> core_halt); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && !release_cmd) |=> core_halt); // R6
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 5'd2 && !if_valid && !da_valid && !ext_dbg_req) |=> (hit_status == 3'b000)); // R5
  AST_IDLE_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_valid && !da_valid && !ext_dbg_req) |=> !dbg_exc); // R5
endmodule

bind bpwp_dbg bpwp_dbg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .if_valid(if_valid), .da_valid(da_valid),
  .ext_dbg_req(ext_dbg_req), .mon_mode(mon_mode), .core_halt(core_halt),
  .dbg_exc(dbg_exc), .hit_status(hit_status)
);

// File: tb/bpwp_dbg_bench.sv
module bpwp_dbg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [4:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic if_valid = 0, insn_retire = 0, da_valid = 0, da_write = 0, ext_dbg_req = 0;
  logic [W-1:0] if_addr = '0, if_data = '0, da_addr = '0, da_data = '0;
  logic core_halt, dbg_exc;
  logic [2:0] hit_status;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bpwp_dbg #(.W(W)) u_bpwp_dbg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .if_valid(if_valid), .if_addr(if_addr), .if_data(if_data), .insn_retire(insn_retire),
    .da_valid(da_valid), .da_write(da_write), .da_addr(da_addr), .da_data(da_data),
    .ext_dbg_req(ext_dbg_req), .core_halt(core_halt), .dbg_exc(dbg_exc), .hit_status(hit_status)
  );

  // {is_data, write, addr, data, expected hits}
  localparam logic [67:0] VEC [8] = '{
    {1'b0, 1'b0, 32'h0000_1004, 32'hE1A0_0000, 2'b01},
    {1'b0, 1'b0, 32'h0000_1004, 32'h0000_0000, 2'b00},
    {1'b0, 1'b0, 32'h0000_1014, 32'hE1A0_0000, 2'b00},
    {1'b1, 1'b1, 32'h0000_2000, 32'h0000_0055, 2'b10},
    {1'b1, 1'b0, 32'h0000_2000, 32'h0000_0055, 2'b00},
    {1'b1, 1'b1, 32'h0000_2004, 32'h0000_0055, 2'b00},
    {1'b0, 1'b0, 32'h0000_2000, 32'h0000_0000, 2'b00},
    {1'b1, 1'b1, 32'h0000_1004, 32'hE1A0_0000, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic bus(input bit is_data, input bit w, input logic [W-1:0] a, input logic [W-1:0] d);
    if (is_data) begin
      da_valid = 1; da_write = w; da_addr = a; da_data = d;
    end else begin
      if_valid = 1; if_addr = a; if_data = d;
    end
    tick();
    if_valid = 0; da_valid = 0; da_write = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk("R1 halt after reset", core_halt, 0);
    chk("R1 exc after reset", dbg_exc, 0);
    chk("R1 status after reset", hit_status, 0);
    rst_n = 1;
    tick();
    bus(0, 0, 32'h0, 32'h0);
    chk("R1 disabled units no halt", core_halt, 0);
    chk("R1 disabled units no status", hit_status, 0);

    // R10 programming: unit0 breakpoint with data qualify, unit1 write watchpoint
    wr(5'd0, 32'd1);
    wr(5'd8, 32'h1000); wr(5'd9, 32'hF); wr(5'd10, 32'hE1A0_0000); wr(5'd11, 32'h0); wr(5'd12, 32'h11);
    wr(5'd16, 32'h2000); wr(5'd17, 32'h0); wr(5'd18, 32'h0); wr(5'd19, 32'h0); wr(5'd20, 32'h0B);

    foreach (VEC[i]) begin
      bus(VEC[i][67], VEC[i][66], VEC[i][65:34], VEC[i][33:2]);
      chk($sformatf("R2/R3/R4 vec%0d status", i), hit_status[1:0], VEC[i][1:0]);
      chk($sformatf("R7 vec%0d exc", i), dbg_exc, |VEC[i][1:0]);
      chk($sformatf("R7 vec%0d no halt", i), core_halt, 0);
      wr(5'd2, 32'h0);
      chk($sformatf("R5 vec%0d cleared", i), hit_status, 0);
    end

    ext_dbg_req = 1; tick(); ext_dbg_req = 0;
    chk("R8 monitor ext exc", dbg_exc, 1);
    chk("R8 ext status bit2", hit_status[2], 1);
    chk("R7 monitor ext no halt", core_halt, 0);
    tick();
    chk("R7 exc is one pulse", dbg_exc, 0);
    chk("R5 status sticky", hit_status[2], 1);

    wr(5'd0, 32'd0);
    bus(0, 0, 32'h1008, 32'hE1A0_0000);
    chk("R6 halt on breakpoint", core_halt, 1);
    chk("R6 no exc in halt mode", dbg_exc, 0);
    repeat (3) tick();
    chk("R6 halt held", core_halt, 1);
    wr(5'd1, 32'd1);
    chk("R9 run releases", core_halt, 0);
    ext_dbg_req = 1; tick(); ext_dbg_req = 0;
    chk("R8 ext halts", core_halt, 1);
    wr(5'd1, 32'd4);
    chk("R9 step releases", core_halt, 0);
    tick();
    chk("R9 step waits for retire", core_halt, 0);
    insn_retire = 1; tick(); insn_retire = 0;
    chk("R9 step re-halts", core_halt, 1);
    wr(5'd1, 32'd1);
    wr(5'd1, 32'd4);
    chk("R9 step while running ignored", core_halt, 0);
    insn_retire = 1; tick(); insn_retire = 0;
    chk("R9 retire after ignored step", core_halt, 0);
    wr(5'd1, 32'd2);
    chk("R9 halt command", core_halt, 1);
    wr(5'd1, 32'd1);

    da_valid = 1; da_write = 1; da_addr = 32'h2000; da_data = 0;
    wr(5'd2, 32'h0);
    da_valid = 0; da_write = 0;
    chk("R5 hit with clear recorded", hit_status, 3'b010);
    wr(5'd1, 32'd1);
    wr(5'd2, 32'h0);
    wr(5'd20, 32'h0A);
    bus(1, 1, 32'h2000, 32'h0);
    chk("R1 disabled unit no halt", core_halt, 0);
    chk("R1 disabled unit no status", hit_status, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule